// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two N-bit two's-complement numbers using radix-2 Booth recoding. It retires one multiplier bit per clock, so a full product takes N cycles. Two registers hold the state. The first keeps the multiplicand, widened by one sign bit. The second is a combined register with a guard bit on the left, the running partial product, the multiplier and one extra bit appended on the right.

On each step the block looks at the two lowest bits of the combined register. Depending on that pair it adds the multiplicand to the upper part, subtracts it, or leaves the upper part alone. It then shifts the whole register right by one place and copies the sign bit into the top. After N steps the guard bit and the appended bit are dropped and the remaining 2N bits are the signed product. A caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse and reads `product`. The product stays on the port until the next accepted start.

Top module: `booth_mult`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 loads the operands, and `busy` is 1 from the next cycle for exactly N consecutive cycles.
- R3: `done` is 1 for exactly one cycle. That cycle follows the last busy cycle, N+1 cycles after the clock edge that accepted `start`, and `busy` is 0 during it.
- R4: When `done` is 1, `product` equals the 2N-bit signed product of the two operands captured at the accepted start.
- R5: The product is exact when either operand, or both, equals the most negative N-bit value (bit N-1 set, all other bits 0).
- R6: After `done`, `product` keeps its value on every cycle until another start is accepted.
- R7: A `start` pulse while `busy` is 1 is ignored. The running operation keeps its timing and its result, and the operands on the inputs are not captured.
- R8: The bit-pair recoding gives correct products for multipliers made of runs of ones, runs of zeros and alternating bits. Pair 01 adds the multiplicand, pair 10 subtracts it, and pairs 00 and 11 add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only when idle |
| multiplicand | input | N | Signed multiplicand, captured on accepted start |
| multiplier | input | N | Signed multiplier, captured on accepted start |
| busy | output | 1 | High while add/shift steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held until the next start |

## Verification
The bench raises `start` for one clock and then samples at each following falling edge. `busy` must read 1 at the first sample. `done` must appear at sample N+1 and at no other sample. The product is compared in the cycle where `done` is seen, and again after a few idle cycles to check that it holds. For the ignored-start case, a second start carrying different operands is driven midway through a run. The bench then checks that `done` still lands at sample N+1 and that the result matches the first operand pair.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Strobes passed from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear the upper half
    logic step;   // one recode-add-shift step
  } ctrlStrobe_t;

  // Action chosen from the two lowest bits of the combined register
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } boothAct_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [1:0] bitPair,
  output boothAct_t  act
);
  always_comb begin
    case (bitPair)
      2'b01:   act = ACT_ADD;
      2'b10:   act = ACT_SUB;
      default: act = ACT_HOLD;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  localparam int CNTW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t stateReg;
  logic [CNTW-1:0] stepCnt;

  always_comb begin
    strobe.load = (stateReg == ST_IDLE) && start;
    strobe.step = (stateReg == ST_RUN);
  end

  assign busy = (stateReg == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg <= ST_IDLE;
      stepCnt  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (stateReg)
        ST_IDLE: begin
          if (start) begin
            stateReg <= ST_RUN;
            stepCnt  <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST) begin
            stateReg <= ST_IDLE;
            done     <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: stateReg <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrlStrobe_t   strobe,
  input  logic [N-1:0]  mcandIn,
  input  logic [N-1:0]  mplierIn,
  output logic [2*N-1:0] product
);
  localparam int AW = N + 1;      // upper half with guard bit
  localparam int CW = 2 * N + 2;  // guard + upper + multiplier + appended bit

  logic [AW-1:0] mcandReg;
  logic [CW-1:0] combReg;
  logic [AW-1:0] upperHalf;
  logic [AW-1:0] sumVal;
  logic [CW-1:0] shifted;
  boothAct_t     act;

  assign upperHalf = combReg[CW-1:N+1];

  booth_recode u_recode (
    .bitPair (combReg[1:0]),
    .act     (act)
  );

  always_comb begin
    case (act)
      ACT_ADD: sumVal = upperHalf + mcandReg;
      ACT_SUB: sumVal = upperHalf - mcandReg;
      default: sumVal = upperHalf;
    endcase
    // arithmetic right shift of {sum, lower bits}
    shifted = {sumVal[AW-1], sumVal, combReg[N:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcandReg <= '0;
      combReg  <= '0;
    end else if (strobe.load) begin
      mcandReg <= {mcandIn[N-1], mcandIn};
      combReg  <= {{AW{1'b0}}, mplierIn, 1'b0};
    end else if (strobe.step) begin
      combReg  <= shifted;
    end
  end

  // drop guard bit and appended bit
  assign product = combReg[2*N:1];
endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  ctrlStrobe_t strobe;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  booth_datapath #(.N(N)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .mcandIn  (multiplicand),
    .mplierIn (multiplier),
    .product  (product)
  );
endmodule

// File: rtl/booth_mult_chk.sv
module booth_mult_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int LW = $clog2(N + 2) + 1;
  logic [LW-1:0] runLen;

  always_ff @(posedge clk) begin
    if (rst)       runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (runLen == LW'(N)));

  // R3
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));
endmodule

bind booth_mult booth_mult_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/booth_mult_tb.sv
module booth_mult_tb;
  localparam int N = 16;
  localparam logic [N-1:0] MOSTNEG = {1'b1, {(N-1){1'b0}}};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   multiplicand = '0;
  logic [N-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  booth_mult #(.N(N)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  function automatic logic [2*N-1:0] refMul(logic [N-1:0] a, logic [N-1:0] b);
    logic signed [2*N-1:0] ea, eb;
    ea = {{N{a[N-1]}}, a};
    eb = {{N{b[N-1]}}, b};
    return ea * eb;
  endfunction

  task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one multiply; optionally injects a second start mid-run.
  task automatic runMul(logic [N-1:0] a, logic [N-1:0] b, string req, bit inject);
    int doneAt = 0;
    int doneCount = 0;
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    start = 1'b1;
    for (int i = 1; i <= N + 3; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (inject && i == N / 2) begin
        multiplicand = ~a;
        multiplier   = b ^ 16'h5a5a;
        start = 1'b1;
      end
      if (i == 1) check("R2 busy after start", {31'b0, busy}, 32'd1);
      if (done) begin
        doneCount++;
        doneAt = i;
        check(req, product, refMul(a, b));
        check("R3 busy low with done", {31'b0, busy}, 32'd0);
      end
    end
    start = 1'b0;
    check("R3 done cycle", doneAt, N + 1);
    check("R3 done width", doneCount, 1);
    check("R6 product held", product, refMul(a, b));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ra, rb;
    void'($urandom(32'd20131007));
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy}, 32'd0);
    check("R1 done in reset", {31'b0, done}, 32'd0);
    check("R1 product in reset", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", {31'b0, busy}, 32'd0);
    check("R1 product after reset", product, '0);

    runMul(16'd3, 16'd7, "R4 small positive", 0);
    runMul(16'hfffd, 16'd7, "R4 negative times positive", 0);
    runMul(16'hfff9, 16'hfffd, "R4 two negatives", 0);
    runMul(MOSTNEG, MOSTNEG, "R5 both most negative", 0);
    runMul(MOSTNEG, 16'd1, "R5 most negative times one", 0);
    runMul(16'hffff, MOSTNEG, "R5 minus one times most negative", 0);
    runMul(16'h7fff, MOSTNEG, "R5 max positive times most negative", 0);
    runMul(16'h1234, 16'hffff, "R8 multiplier all ones", 0);
    runMul(16'h1234, 16'h5555, "R8 alternating 01", 0);
    runMul(16'hedcb, 16'haaaa, "R8 alternating 10", 0);
    runMul(16'h4321, 16'h0ff0, "R8 runs of ones", 0);
    runMul(16'h7fff, 16'h0000, "R8 zero multiplier", 0);
    runMul(16'h0123, 16'h4567, "R7 start while busy ignored", 1);

    repeat (4) @(negedge clk);
    check("R6 product still held", product, refMul(16'h0123, 16'h4567));

    for (int k = 0; k < 40; k++) begin
      ra = N'($urandom);
      rb = N'($urandom);
      runMul(ra, rb, "R4 random operands", 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule